// File: doc/BRIEF.md
# Telemetry Packet Stream Generator

This block turns a stream of 10-bit converter samples into a framed serial bit stream. A session sends a fixed number of packets. Each packet opens with a 12-bit header word, carries a configured number of 12-bit sample words, and may close with a 12-bit tail that is the bitwise inverse of the header. A run of low bits follows each packet. The length of that run is a whole number of packet lengths. The serial line shifts one bit per tick. The tick comes from the 8 MHz base clock divided by a programmable amount.

The host drives the configuration inputs and raises the start input to begin a session. The block latches the configuration at that moment. It then pulls one sample from the sample source each time a sample word is due, and it names the channel (0 to 7, in a cycle) that it wants. When no sample is offered at that moment, the block flags a stall and sends the previous value again. The busy output covers the whole session, including the quiet run after the last packet.

Top module: `telem_framer`

## Requirements
- R1: After reset and whenever busy is 0, ser_out, busy and smp_ready are all 0.
- R2: Every packet starts with the 12 bits of the latched header, most significant bit first.
- R3: The header is followed by exactly N sample words, where N is the latched data count. Each word is sent MSB first and holds, from bit 11 down: a stale flag (bit 11), a first-channel flag that is 1 when the word's channel is 0 (bit 10), and the 10-bit sample value (bits 9:0).
- R4: With tail enable set, the inverse of the header follows the last sample word (or follows the header when N is 0). With tail enable clear, no tail is sent.
- R5: Every serial bit, quiet bits included, lasts exactly (divider value + 1) clock cycles.
- R6: After every packet, including the last one, ser_out stays 0 for gap × 12 × (1 + N + tail) bit times. busy falls right after the final quiet run.
- R7: A packet count of 0 sends nothing and busy stays 0. A count of 1 sends 2 packets. Any other count v sends v + 1 packets.
- R8: A session starts only on a 0-to-1 change of cfg_start seen while idle. A start held high through reset does not start one. A new edge during a session is ignored, and configuration changes during a session have no effect on it.
- R9: smp_ready pulses once per sample word, in the cycle that word is loaded. smp_chan gives the channel for that word. Channels run 0..7 and wrap, and they restart at 0 with each session.
- R10: If smp_valid is 0 when a word is loaded, smp_stall pulses in that cycle. The word then carries stale = 1 and the last accepted sample value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_header | input | 12 | Packet header word |
| cfg_num_data | input | ND_W | Sample words per packet |
| cfg_num_pkts | input | NP_W | Packet count code |
| cfg_div | input | DIV_W | Bit-time divider minus one |
| cfg_gap | input | GAP_W | Quiet run after each packet, in packet lengths |
| cfg_tail_en | input | 1 | Append inverted header as tail |
| cfg_start | input | 1 | Session start, acts on a rising edge |
| smp_valid | input | 1 | A sample is offered |
| smp_data | input | 10 | Offered sample value |
| smp_ready | output | 1 | Sample taken this cycle |
| smp_chan | output | 3 | Channel of the word being loaded |
| smp_stall | output | 1 | Word loaded without a valid sample |
| ser_out | output | 1 | Serial telemetry line |
| busy | output | 1 | Session in progress |

## Verification
Two things can happen in the same clock cycle: a sample word is loaded (with a stall when no sample is offered), and the last bit of the previous field ends. The stall case is provoked by running a whole session with smp_valid low. The bench then expects every word to be flagged stale and to repeat the value last accepted in the previous session. A second clash is forced on purpose: a fresh start edge, together with a new header, is driven in the middle of a running session. The bit stream is then judged against the header latched at the start, and busy is checked to stay low once that session ends.

// File: rtl/telem_pkg.sv
package telem_pkg;

    localparam int HDR_W  = 12;
    localparam int SMP_W  = 10;
    localparam int WORD_W = 12;
    localparam int CH_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_TAIL,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic             stale;
        logic             first_ch;
        logic [SMP_W-1:0] value;
    } smp_word_t;

    function automatic logic is_sending(seq_state_t s);
        return (s == ST_HDR) || (s == ST_DATA) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/telem_start_edge.sv
module telem_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic start_in,
    output logic rise
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b1;
        else     start_q <= start_in;
    end

    assign rise = start_in & ~start_q;
endmodule

// File: rtl/telem_bit_timer.sv
module telem_bit_timer #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/telem_word_src.sv
module telem_word_src
    import telem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output smp_word_t        word,
    output logic [CH_W-1:0]  chan,
    output logic             stall
);
    logic [SMP_W-1:0] held;

    always_comb begin
        word.stale    = ~smp_valid;
        word.first_ch = (chan == '0);
        word.value    = smp_valid ? smp_data : held;
    end

    assign stall = load & ~smp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            chan <= '0;
        end else if (clear) begin
            chan <= '0;
        end else if (load) begin
            chan <= chan + 1'b1;
            if (smp_valid) held <= smp_data;
        end
    end
endmodule

// File: rtl/telem_framer.sv
module telem_framer
    import telem_pkg::*;
#(
    parameter int ND_W  = 8,
    parameter int NP_W  = 8,
    parameter int GAP_W = 4,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HDR_W-1:0] cfg_header,
    input  logic [ND_W-1:0]  cfg_num_data,
    input  logic [NP_W-1:0]  cfg_num_pkts,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             cfg_tail_en,
    input  logic             cfg_start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             smp_ready,
    output logic [CH_W-1:0]  smp_chan,
    output logic             smp_stall,
    output logic             ser_out,
    output logic             busy
);
    localparam int PC_W   = NP_W + 1;
    localparam int LEN_W  = ND_W + 5;
    localparam int GAPB_W = LEN_W + GAP_W;
    localparam int BI_W   = $clog2(WORD_W);

    seq_state_t        state;
    logic [HDR_W-1:0]  hdr_q;
    logic [ND_W-1:0]   nd_q;
    logic              tail_q;
    logic [DIV_W-1:0]  div_q;
    logic [GAPB_W-1:0] gapbits_q, gap_cnt;
    logic [PC_W-1:0]   pkts_left;
    logic [WORD_W-1:0] shreg;
    logic [BI_W-1:0]   bit_idx;
    logic [ND_W-1:0]   word_idx;

    logic       start_rise, fire, tick;
    logic       last_bit, word_load, goto_tail, pkt_done, gap_done;
    smp_word_t  next_word;
    logic [LEN_W-1:0]  plen;
    logic [GAPB_W-1:0] gapbits;
    logic [PC_W-1:0]   pkts_eff;

    telem_start_edge u_edge (
        .clk(clk), .rst(rst), .start_in(cfg_start), .rise(start_rise)
    );

    telem_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(state != ST_IDLE), .div(div_q), .tick(tick)
    );

    telem_word_src u_src (
        .clk(clk), .rst(rst), .clear(fire), .load(word_load),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .word(next_word), .chan(smp_chan), .stall(smp_stall)
    );

    always_comb begin
        plen    = LEN_W'(12) * (LEN_W'(1) + LEN_W'(cfg_num_data) + LEN_W'(cfg_tail_en));
        gapbits = GAPB_W'(cfg_gap) * GAPB_W'(plen);
        if (cfg_num_pkts == '0)                pkts_eff = '0;
        else if (cfg_num_pkts == NP_W'(1))     pkts_eff = PC_W'(2);
        else                                   pkts_eff = PC_W'(cfg_num_pkts) + 1'b1;
    end

    assign fire = start_rise && (state == ST_IDLE) && (cfg_num_pkts != '0);

    always_comb begin
        last_bit  = tick && is_sending(state) && (bit_idx == BI_W'(WORD_W - 1));
        word_load = last_bit &&
                    (((state == ST_HDR) && (nd_q != '0)) ||
                     ((state == ST_DATA) && (word_idx != nd_q - 1'b1)));
        goto_tail = last_bit && !word_load && tail_q && (state != ST_TAIL);
        pkt_done  = last_bit && !word_load && !goto_tail;
        gap_done  = (state == ST_GAP) && tick && (gap_cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hdr_q     <= '0;
            nd_q      <= '0;
            tail_q    <= 1'b0;
            div_q     <= '0;
            gapbits_q <= '0;
            gap_cnt   <= '0;
            pkts_left <= '0;
            shreg     <= '0;
            bit_idx   <= '0;
            word_idx  <= '0;
        end else if (fire) begin
            state     <= ST_HDR;
            hdr_q     <= cfg_header;
            nd_q      <= cfg_num_data;
            tail_q    <= cfg_tail_en;
            div_q     <= cfg_div;
            gapbits_q <= gapbits;
            pkts_left <= pkts_eff;
            shreg     <= cfg_header;
            bit_idx   <= '0;
        end else if (word_load) begin
            state    <= ST_DATA;
            shreg    <= next_word;
            bit_idx  <= '0;
            word_idx <= (state == ST_HDR) ? '0 : word_idx + 1'b1;
        end else if (goto_tail) begin
            state   <= ST_TAIL;
            shreg   <= ~hdr_q;
            bit_idx <= '0;
        end else if (pkt_done) begin
            pkts_left <= pkts_left - 1'b1;
            bit_idx   <= '0;
            if (gapbits_q != '0) begin
                state   <= ST_GAP;
                gap_cnt <= gapbits_q - 1'b1;
            end else if (pkts_left == PC_W'(1)) begin
                state <= ST_IDLE;
            end else begin
                state <= ST_HDR;
                shreg <= hdr_q;
            end
        end else if (gap_done) begin
            if (pkts_left == '0) begin
                state <= ST_IDLE;
            end else begin
                state   <= ST_HDR;
                shreg   <= hdr_q;
                bit_idx <= '0;
            end
        end else if (tick && is_sending(state)) begin
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end else if (tick && (state == ST_GAP)) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign ser_out   = is_sending(state) && shreg[WORD_W-1];
    assign busy      = (state != ST_IDLE);
    assign smp_ready = word_load;
endmodule

// File: rtl/telem_framer_chk.sv
module telem_framer_chk (
    input logic clk,
    input logic rst,
    input logic cfg_start,
    input logic smp_valid,
    input logic smp_ready,
    input logic smp_stall,
    input logic ser_out,
    input logic busy
);
    // R1
    idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_out && !smp_ready));

    // R9
    ready_in_session_chk: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> busy);

    // R10
    stall_when_starved_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stall |-> (smp_ready && !smp_valid));

    // R8
    start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cfg_start) && !$past(cfg_start, 2)));
endmodule

bind telem_framer telem_framer_chk u_chk (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_stall(smp_stall), .ser_out(ser_out), .busy(busy)
);

// File: tb/test_telem_framer.sv
module test_telem_framer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [11:0] hdr;
        logic [7:0]  nd;
        logic [7:0]  np;
        logic [5:0]  div;
        logic [3:0]  gap;
        logic        tail;
        logic        valid;
        logic [6:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'h56A, 8'd1,  8'd1, 6'd0, 4'd0, 1'b1, 1'b1, 7'h15},
        '{12'h9C3, 8'd3,  8'd3, 6'd1, 4'd1, 1'b0, 1'b1, 7'h2A},
        '{12'hFFF, 8'd0,  8'd2, 6'd0, 4'd0, 1'b1, 1'b1, 7'h00},
        '{12'h0A5, 8'd2,  8'd2, 6'd2, 4'd0, 1'b1, 1'b0, 7'h00},
        '{12'h123, 8'd10, 8'd2, 6'd0, 4'd2, 1'b0, 1'b1, 7'h7F},
        '{12'h3C3, 8'd2,  8'd0, 6'd0, 4'd0, 1'b1, 1'b1, 7'h01}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] cfg_header = '0;
    logic [7:0]  cfg_num_data = '0;
    logic [7:0]  cfg_num_pkts = '0;
    logic [5:0]  cfg_div = '0;
    logic [3:0]  cfg_gap = '0;
    logic        cfg_tail_en = 0;
    logic        cfg_start = 0;
    logic        smp_valid = 0;
    logic [9:0]  smp_data;
    logic [6:0]  seed = '0;
    logic        smp_ready, smp_stall, ser_out, busy;
    logic [2:0]  smp_chan;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_comb smp_data = {smp_chan, seed};

    telem_framer i_telem_framer (
        .clk(clk), .rst(rst), .cfg_header(cfg_header), .cfg_num_data(cfg_num_data),
        .cfg_num_pkts(cfg_num_pkts), .cfg_div(cfg_div), .cfg_gap(cfg_gap),
        .cfg_tail_en(cfg_tail_en), .cfg_start(cfg_start), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_ready(smp_ready), .smp_chan(smp_chan),
        .smp_stall(smp_stall), .ser_out(ser_out), .busy(busy)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    bit exp_bits [0:4095];
    int n_exp;
    logic [9:0] model_last = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) begin
            exp_bits[n_exp] = w[i];
            n_exp++;
        end
    endtask

    task automatic idle_hold(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy || ser_out) seen++;
        end
        chk(seen == 0, req, "busy/line stays low", seen, 0);
    endtask

    task automatic run_session(input vec_t v, input bit disturb);
        int P, D, L, cyc, mism, first_bad, rdy, stl, chan;
        logic [9:0] val;
        P = (v.np == 0) ? 0 : (v.np == 1) ? 2 : int'(v.np) + 1;
        D = int'(v.div) + 1;
        L = 12 * (1 + int'(v.nd) + int'(v.tail));
        n_exp = 0; chan = 0;
        for (int p = 0; p < P; p++) begin
            push(v.hdr);
            for (int w = 0; w < int'(v.nd); w++) begin
                val = v.valid ? {3'(chan), v.seed} : model_last;
                if (v.valid) model_last = val;
                push({~v.valid, chan == 0, val});
                chan = (chan + 1) % 8;
            end
            if (v.tail) push(~v.hdr);
            for (int g = 0; g < int'(v.gap) * L; g++) begin
                exp_bits[n_exp] = 1'b0;
                n_exp++;
            end
        end
        @(negedge clk);
        cfg_header = v.hdr; cfg_num_data = v.nd; cfg_num_pkts = v.np;
        cfg_div = v.div; cfg_gap = v.gap; cfg_tail_en = v.tail;
        smp_valid = v.valid; seed = v.seed; cfg_start = 1;
        @(negedge clk);
        if (P == 0) begin
            idle_hold("R7", 20);
        end else begin
            cyc = 0; mism = 0; first_bad = -1; rdy = 0; stl = 0;
            while (busy && cyc < 20000) begin
                if (disturb && cyc == 20) cfg_start = 0;
                if (disturb && cyc == 25) begin
                    cfg_start = 1; cfg_header = ~v.hdr; cfg_div = 6'd0;
                end
                if (cyc / D < n_exp && ser_out !== exp_bits[cyc / D]) begin
                    mism++;
                    if (first_bad < 0) first_bad = cyc;
                end
                if (smp_ready) rdy++;
                if (smp_stall) stl++;
                cyc++;
                @(negedge clk);
            end
            chk(mism == 0, disturb ? "R8" : "R2/R3/R4",
                "serial bit mismatches (first at cycle)", first_bad, -1);
            chk(cyc == D * n_exp, "R5/R6", "session length in cycles", cyc, D * n_exp);
            chk(rdy == P * int'(v.nd), "R9", "sample handshakes", rdy, P * int'(v.nd));
            chk(stl == (v.valid ? 0 : P * int'(v.nd)), "R10", "stall pulses", stl,
                v.valid ? 0 : P * int'(v.nd));
            if (disturb) idle_hold("R8", 15);
        end
        cfg_start = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t dv;
        repeat (3) @(negedge clk);
        chk(!ser_out && !busy && !smp_ready, "R1", "outputs during reset",
            {ser_out, busy, smp_ready}, 0);
        rst = 0;
        @(negedge clk);
        chk(!ser_out && !busy && !smp_ready, "R1", "outputs after reset",
            {ser_out, busy, smp_ready}, 0);

        for (int i = 0; i < NV; i++) run_session(VECS[i], 1'b0);

        dv = '{12'h5A5, 8'd1, 8'd2, 6'd1, 4'd0, 1'b0, 1'b1, 7'h03};
        run_session(dv, 1'b1);

        // R8: start held high across reset must not begin a session
        @(negedge clk);
        cfg_num_pkts = 8'd2; cfg_start = 1; rst = 1;
        repeat (2) @(negedge clk);
        rst = 0; model_last = '0;
        idle_hold("R8", 20);
        cfg_start = 0;
        @(negedge clk);

        // R10 after reset: stale words repeat the reset value 0
        run_session('{12'h0F0, 8'd1, 8'd1, 6'd0, 4'd0, 1'b0, 1'b0, 7'h00}, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule